// File: doc/BRIEF.md
# Link Direction Token Controller

This block decides which of two processors may drive a shared bidirectional link. The link has eight data lines and four active-low control lines: request, acknowledge, strobe and ready. One side holds the token and drives the data, strobe and acknowledge lines. The other side drives request and ready. To reverse the link, the side without the token pulls request low. The holder answers with a low acknowledge. Once a word transfer in progress has finished, the pins change direction in a fixed order, so that no line ever has two drivers.

Each pin is presented to the surrounding pad logic as three parts: an output value, an output enable and a raw input. Every incoming control line goes through a synchronizer. Its first stage captures on the falling clock edge and the later stages on rising edges. The block reports the synchronized control levels, a registered copy of the data lines and a flag that is high while it holds the token. A static input selects at reset whether the instance starts as token holder. Two instances, one configured each way, make a complete link when their pins are joined with pull-ups.

Top module: `link_token_ctrl`

## Requirements
- R1: After reset an instance with boot_owner=1 drives data, strobe and acknowledge, with acknowledge high. It leaves request and ready undriven and has token_held=1. An instance with boot_owner=0 drives request high and drives ready while the acknowledge pin reads high. It leaves data, strobe and acknowledge undriven and has token_held=0.
- R2: A non-holder with want_token high drives request low exactly REQ_GAP+1 cycles after it began driving request high. It drives request low never sooner than that.
- R3: An idle holder drives acknowledge low at least one and at most SYNC_STAGES+1 cycles after the request pin falls.
- R4: A holder with word_busy high keeps acknowledge high while the ready line reads high. It grants only after ready reads low.
- R5: Acknowledge goes low on a rising edge. At the following falling edge, half a period later, the holder stops driving the data lines and starts driving ready high.
- R6: A requester that sees acknowledge low stops driving request, and the pull-up makes the line high. When the old holder sees request high, it drives request high and stops driving acknowledge and strobe.
- R7: The new holder begins driving data, strobe and acknowledge TAKE_GAP cycles after it sees acknowledge low. Acknowledge is driven high at that moment.
- R8: While it does not hold the token, an instance drives ready with the value of word_rdy_n. It releases ready immediately and combinationally when the raw acknowledge pin reads low. It also releases ready once it has begun taking the token.
- R9: On a link of two instances, no pin is ever driven by both sides.
- R10: req_s, ack_s, strb_s and rdy_s follow their pins through a synchronizer of SYNC_STAGES stages. dat_s equals the data pins as they stood one cycle earlier.
- R11: While holding the token in its idle or transfer state, an instance drives dat_o with tx_data and strobe with word_strb_n.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| boot_owner | input | 1 | Static: 1 makes this side the token holder at reset |
| want_token | input | 1 | Local request to become the holder |
| word_busy | input | 1 | Holder has a word in flight |
| word_strb_n | input | 1 | Strobe level to drive while holding the token |
| word_rdy_n | input | 1 | Ready level to drive while not holding the token |
| tx_data | input | W | Data to drive while holding the token |
| req_i | input | 1 | Request pin input |
| ack_i | input | 1 | Acknowledge pin input |
| strb_i | input | 1 | Strobe pin input |
| rdy_i | input | 1 | Ready pin input |
| dat_i | input | W | Data pin inputs |
| req_o | output | 1 | Request pin output value |
| req_oe | output | 1 | Request pin output enable |
| ack_o | output | 1 | Acknowledge pin output value |
| ack_oe | output | 1 | Acknowledge pin output enable |
| strb_o | output | 1 | Strobe pin output value |
| strb_oe | output | 1 | Strobe pin output enable |
| rdy_o | output | 1 | Ready pin output value |
| rdy_oe | output | 1 | Ready pin output enable |
| dat_o | output | W | Data pin output values |
| dat_oe | output | 1 | Output enable for all data pins |
| req_s | output | 1 | Synchronized request level |
| ack_s | output | 1 | Synchronized acknowledge level |
| strb_s | output | 1 | Synchronized strobe level |
| rdy_s | output | 1 | Synchronized ready level |
| dat_s | output | W | Data pins registered once |
| token_held | output | 1 | High while this side holds the token |

## Verification
The hardest case is a request that arrives while the holder has a word in flight. The grant must wait for the receiver's ready to fall, and ready is an output of the requesting instance, not of the holder. The bench therefore joins two instances through pull-up wire models. It holds the holder's word_busy and the requester's word_rdy_n high, and only then raises want_token. It keeps the grant pending for a dozen cycles before it lowers word_rdy_n. Four complete handoffs run in both directions, one of them started automatically by a waiting request. This exercises every turnaround order while a half-cycle monitor looks for drivers that overlap.

// File: rtl/tokx_pkg.sv
package tokx_pkg;

  typedef enum logic [2:0] {
    OWN_IDLE = 3'd0,
    OWN_XFER = 3'd1,
    GRANT    = 3'd2,
    RELEASE  = 3'd3,
    WAIT_OWN = 3'd4,
    REQUEST  = 3'd5
  } link_state_t;

  // counter width able to hold n, at least one bit
  function automatic int cnt_width(input int n);
    int w;
    w = $clog2(n + 1);
    return (w < 1) ? 1 : w;
  endfunction

  // states in which this side still drives acknowledge and strobe
  function automatic logic holds_pins(input link_state_t s);
    return (s == OWN_IDLE) || (s == OWN_XFER) || (s == GRANT) || (s == RELEASE);
  endfunction

  // states after the acknowledge has been pulled low
  function automatic logic in_handover(input link_state_t s);
    return (s == GRANT) || (s == RELEASE);
  endfunction

  // states in which this side drives data as holder
  function automatic logic in_service(input link_state_t s);
    return (s == OWN_IDLE) || (s == OWN_XFER);
  endfunction

endpackage

// File: rtl/tokx_sync.sv
module tokx_sync #(
  parameter int  STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);

  logic first_q;

  // first stage samples on the falling edge
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) first_q <= RST_VAL;
    else        first_q <= d;
  end

  generate
    if (STAGES <= 2) begin : g_short
      logic last_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) last_q <= RST_VAL;
        else        last_q <= first_q;
      end
      assign q = last_q;
    end else begin : g_long
      logic [STAGES-2:0] chain_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= {(STAGES-1){RST_VAL}};
        else        chain_q <= {chain_q[STAGES-3:0], first_q};
      end
      assign q = chain_q[STAGES-2];
    end
  endgenerate

endmodule

// File: rtl/tokx_fsm.sv
module tokx_fsm
  import tokx_pkg::*;
#(
  parameter int REQ_GAP  = 2,
  parameter int TAKE_GAP = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        boot_owner,
  input  logic        want_token,
  input  logic        word_busy,
  input  logic        req_s,
  input  logic        ack_s,
  input  logic        rdy_s,
  output link_state_t state,
  output logic        take_phase,
  output logic        turn_q,
  output logic        grant_go
);

  localparam int GW = cnt_width(REQ_GAP);
  localparam int TW = cnt_width(TAKE_GAP);

  logic [GW-1:0] gap_cnt;
  logic [TW-1:0] take_cnt;

  // grant decision: idle holder grants at once, busy holder waits for ready low
  always_comb begin
    grant_go = 1'b0;
    if (state == OWN_IDLE) grant_go = !req_s;
    if (state == OWN_XFER) grant_go = !req_s && !rdy_s;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= boot_owner ? OWN_IDLE : WAIT_OWN;
      gap_cnt    <= GW'(REQ_GAP);
      take_cnt   <= '0;
      take_phase <= 1'b0;
    end else begin
      unique case (state)
        OWN_IDLE: begin
          if (grant_go)       state <= GRANT;
          else if (word_busy) state <= OWN_XFER;
        end
        OWN_XFER: begin
          if (grant_go)        state <= GRANT;
          else if (!word_busy) state <= OWN_IDLE;
        end
        GRANT:   state <= RELEASE;
        RELEASE: begin
          if (req_s) begin
            state   <= WAIT_OWN;
            gap_cnt <= GW'(REQ_GAP);
          end
        end
        WAIT_OWN: begin
          if (gap_cnt != '0) gap_cnt <= gap_cnt - 1'b1;
          else if (want_token) begin
            state      <= REQUEST;
            take_phase <= 1'b0;
          end
        end
        REQUEST: begin
          if (!take_phase) begin
            if (!ack_s) begin
              take_phase <= 1'b1;
              take_cnt   <= TW'(TAKE_GAP - 1);
            end
          end else if (take_cnt == '0) begin
            state      <= OWN_IDLE;
            take_phase <= 1'b0;
          end else begin
            take_cnt <= take_cnt - 1'b1;
          end
        end
        default: state <= WAIT_OWN;
      endcase
    end
  end

  // half-period turnaround marker, set on the falling edge after the grant
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) turn_q <= 1'b0;
    else        turn_q <= in_handover(state);
  end

endmodule

// File: rtl/tokx_pins.sv
module tokx_pins
  import tokx_pkg::*;
#(
  parameter int W = 8
) (
  input  link_state_t  state,
  input  logic         turn_q,
  input  logic         take_phase,
  input  logic         ack_i,
  input  logic         word_strb_n,
  input  logic         word_rdy_n,
  input  logic [W-1:0] tx_data,
  output logic         req_o,
  output logic         req_oe,
  output logic         ack_o,
  output logic         ack_oe,
  output logic         strb_o,
  output logic         strb_oe,
  output logic         rdy_o,
  output logic         rdy_oe,
  output logic [W-1:0] dat_o,
  output logic         dat_oe
);

  logic holding, handing, serving, waiting, asking;

  always_comb begin
    holding = holds_pins(state);
    handing = in_handover(state);
    serving = in_service(state);
    waiting = (state == WAIT_OWN);
    asking  = (state == REQUEST) && !take_phase;

    ack_oe  = holding;
    ack_o   = !handing;
    strb_oe = holding;
    strb_o  = handing ? 1'b1 : word_strb_n;
    dat_oe  = serving || (handing && !turn_q);
    dat_o   = tx_data;
    req_oe  = waiting || asking;
    req_o   = !asking;
    rdy_oe  = (handing && turn_q) || ((waiting || asking) && ack_i);
    rdy_o   = handing ? 1'b1 : word_rdy_n;
  end

endmodule

// File: rtl/link_token_ctrl.sv
module link_token_ctrl
  import tokx_pkg::*;
#(
  parameter int W           = 8,
  parameter int SYNC_STAGES = 2,
  parameter int REQ_GAP     = 2,
  parameter int TAKE_GAP    = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         boot_owner,
  input  logic         want_token,
  input  logic         word_busy,
  input  logic         word_strb_n,
  input  logic         word_rdy_n,
  input  logic [W-1:0] tx_data,
  input  logic         req_i,
  input  logic         ack_i,
  input  logic         strb_i,
  input  logic         rdy_i,
  input  logic [W-1:0] dat_i,
  output logic         req_o,
  output logic         req_oe,
  output logic         ack_o,
  output logic         ack_oe,
  output logic         strb_o,
  output logic         strb_oe,
  output logic         rdy_o,
  output logic         rdy_oe,
  output logic [W-1:0] dat_o,
  output logic         dat_oe,
  output logic         req_s,
  output logic         ack_s,
  output logic         strb_s,
  output logic         rdy_s,
  output logic [W-1:0] dat_s,
  output logic         token_held
);

  localparam int NCTL = 4;

  logic [NCTL-1:0] ctl_raw, ctl_sync;
  link_state_t     state;
  logic            take_phase, turn_q, grant_go;

  assign ctl_raw = {req_i, ack_i, strb_i, rdy_i};

  generate
    for (genvar k = 0; k < NCTL; k++) begin : g_sync
      tokx_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(ctl_raw[k]), .q(ctl_sync[k])
      );
    end
  endgenerate

  assign {req_s, ack_s, strb_s, rdy_s} = ctl_sync;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dat_s <= '0;
    else        dat_s <= dat_i;
  end

  tokx_fsm #(.REQ_GAP(REQ_GAP), .TAKE_GAP(TAKE_GAP)) u_fsm (
    .clk(clk), .rst_n(rst_n), .boot_owner(boot_owner),
    .want_token(want_token), .word_busy(word_busy),
    .req_s(req_s), .ack_s(ack_s), .rdy_s(rdy_s),
    .state(state), .take_phase(take_phase), .turn_q(turn_q),
    .grant_go(grant_go)
  );

  tokx_pins #(.W(W)) u_pins (
    .state(state), .turn_q(turn_q), .take_phase(take_phase),
    .ack_i(ack_i), .word_strb_n(word_strb_n), .word_rdy_n(word_rdy_n),
    .tx_data(tx_data),
    .req_o(req_o), .req_oe(req_oe), .ack_o(ack_o), .ack_oe(ack_oe),
    .strb_o(strb_o), .strb_oe(strb_oe), .rdy_o(rdy_o), .rdy_oe(rdy_oe),
    .dat_o(dat_o), .dat_oe(dat_oe)
  );

  assign token_held = holds_pins(state);

endmodule

// File: rtl/tokx_chk.sv
module tokx_chk
  import tokx_pkg::*;
#(
  parameter int REQ_GAP = 2
) (
  input logic        clk,
  input logic        rst_n,
  input link_state_t state,
  input logic        ack_i,
  input logic        req_o,
  input logic        req_oe,
  input logic        ack_o,
  input logic        ack_oe,
  input logic        strb_oe,
  input logic        dat_oe,
  input logic        rdy_o,
  input logic        rdy_oe,
  input logic        req_s,
  input logic        rdy_s,
  input logic        token_held
);

  localparam int HW = cnt_width(REQ_GAP + 2);

  logic [HW-1:0] high_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   high_cnt <= '0;
    else if (!(req_oe && req_o))  high_cnt <= '0;
    else if (high_cnt != '1)      high_cnt <= high_cnt + 1'b1;
  end

  // R2
  req_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(req_o) && req_oe) |-> (int'(high_cnt) >= REQ_GAP));

  // R3
  grant_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(ack_o) && ack_oe) |-> !$past(req_s));

  // R4
  busy_defer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(ack_o) && ack_oe && $past(state) == OWN_XFER) |-> !$past(rdy_s));

  // R5
  turn_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dat_oe |-> !rdy_oe);

  // R5
  rdy_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rdy_oe && token_held) |-> rdy_o);

  // R7
  take_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dat_oe) |-> (ack_oe && ack_o && strb_oe));

  // R8
  rdy_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ack_i && !token_held) |-> !rdy_oe);

  // R9
  role_split_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack_oe |-> !req_oe);

endmodule

bind link_token_ctrl tokx_chk #(.REQ_GAP(REQ_GAP)) u_chk (
  .clk(clk), .rst_n(rst_n), .state(state), .ack_i(ack_i),
  .req_o(req_o), .req_oe(req_oe), .ack_o(ack_o), .ack_oe(ack_oe),
  .strb_oe(strb_oe), .dat_oe(dat_oe), .rdy_o(rdy_o), .rdy_oe(rdy_oe),
  .req_s(req_s), .rdy_s(rdy_s), .token_held(token_held)
);

// File: tb/link_token_ctrl_test.sv
`timescale 1ns/100ps
module link_token_ctrl_test;

  localparam int W = 8;
  localparam int SYNC_STAGES = 2;
  localparam int REQ_GAP = 2;
  localparam int TAKE_GAP = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  // local-side stimulus for both instances
  logic u_want = 0, u_busy = 0, u_strbv = 1, u_rdyv = 1;
  logic p_want = 0, p_busy = 0, p_strbv = 1, p_rdyv = 1;
  logic [W-1:0] u_tx = '0, p_tx = '0;

  logic u_req_o, u_req_oe, u_ack_o, u_ack_oe, u_strb_o, u_strb_oe, u_rdy_o, u_rdy_oe, u_dat_oe;
  logic p_req_o, p_req_oe, p_ack_o, p_ack_oe, p_strb_o, p_strb_oe, p_rdy_o, p_rdy_oe, p_dat_oe;
  logic u_req_s, u_ack_s, u_strb_s, u_rdy_s, u_hold;
  logic p_req_s, p_ack_s, p_strb_s, p_rdy_s, p_hold;
  logic [W-1:0] u_dat_o, p_dat_o, u_dat_s, p_dat_s;

  // pulled-up link wires
  wire req_w  = u_req_oe  ? u_req_o  : (p_req_oe  ? p_req_o  : 1'b1);
  wire ack_w  = u_ack_oe  ? u_ack_o  : (p_ack_oe  ? p_ack_o  : 1'b1);
  wire strb_w = u_strb_oe ? u_strb_o : (p_strb_oe ? p_strb_o : 1'b1);
  wire rdy_w  = u_rdy_oe  ? u_rdy_o  : (p_rdy_oe  ? p_rdy_o  : 1'b1);
  wire [W-1:0] dat_w = u_dat_oe ? u_dat_o : (p_dat_oe ? p_dat_o : {W{1'b1}});

  link_token_ctrl #(.W(W), .SYNC_STAGES(SYNC_STAGES), .REQ_GAP(REQ_GAP), .TAKE_GAP(TAKE_GAP)) uut (
    .clk(clk), .rst_n(rst_n), .boot_owner(1'b1), .want_token(u_want), .word_busy(u_busy),
    .word_strb_n(u_strbv), .word_rdy_n(u_rdyv), .tx_data(u_tx),
    .req_i(req_w), .ack_i(ack_w), .strb_i(strb_w), .rdy_i(rdy_w), .dat_i(dat_w),
    .req_o(u_req_o), .req_oe(u_req_oe), .ack_o(u_ack_o), .ack_oe(u_ack_oe),
    .strb_o(u_strb_o), .strb_oe(u_strb_oe), .rdy_o(u_rdy_o), .rdy_oe(u_rdy_oe),
    .dat_o(u_dat_o), .dat_oe(u_dat_oe),
    .req_s(u_req_s), .ack_s(u_ack_s), .strb_s(u_strb_s), .rdy_s(u_rdy_s),
    .dat_s(u_dat_s), .token_held(u_hold)
  );

  link_token_ctrl #(.W(W), .SYNC_STAGES(SYNC_STAGES), .REQ_GAP(REQ_GAP), .TAKE_GAP(TAKE_GAP)) peer (
    .clk(clk), .rst_n(rst_n), .boot_owner(1'b0), .want_token(p_want), .word_busy(p_busy),
    .word_strb_n(p_strbv), .word_rdy_n(p_rdyv), .tx_data(p_tx),
    .req_i(req_w), .ack_i(ack_w), .strb_i(strb_w), .rdy_i(rdy_w), .dat_i(dat_w),
    .req_o(p_req_o), .req_oe(p_req_oe), .ack_o(p_ack_o), .ack_oe(p_ack_oe),
    .strb_o(p_strb_o), .strb_oe(p_strb_oe), .rdy_o(p_rdy_o), .rdy_oe(p_rdy_oe),
    .dat_o(p_dat_o), .dat_oe(p_dat_oe),
    .req_s(p_req_s), .ack_s(p_ack_s), .strb_s(p_strb_s), .rdy_s(p_rdy_s),
    .dat_s(p_dat_s), .token_held(p_hold)
  );

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  // expected gap between request driven high and request low, restated here
  function automatic int exp_gap(input int gap);
    return gap + 1;
  endfunction

  // scoreboard of token ownership changes: who=0 uut, who=1 peer
  typedef struct packed { logic who; logic val; } tok_ev_t;
  tok_ev_t exp_q[$];
  bit mon_on = 1'b0;
  logic u_prev = 1'b1, p_prev = 1'b0;

  task automatic expect_ev(input logic who, input logic val);
    tok_ev_t e;
    e.who = who;
    e.val = val;
    exp_q.push_back(e);
  endtask

  task automatic pop_cmp(input logic who, input logic val);
    tok_ev_t e;
    if (exp_q.size() == 0) begin
      chk(1'b0, "R6", "unexpected token change", {who, val}, 0);
    end else begin
      e = exp_q.pop_front();
      chk(e.who == who && e.val == val, "R7", "token change order", {who, val}, {e.who, e.val});
    end
  endtask

  always @(posedge clk) begin
    #1;
    if (mon_on) begin
      if (u_hold != u_prev) pop_cmp(1'b0, u_hold);
      if (p_hold != p_prev) pop_cmp(1'b1, p_hold);
    end
    u_prev = u_hold;
    p_prev = p_hold;
  end

  // peer request-high run length
  int p_hi = 0;
  int p_gap_seen = -1;
  always @(posedge clk) begin
    #1;
    if (rst_n) begin
      if (p_req_oe && p_req_o) p_hi++;
      else begin
        if (p_hi != 0 && p_req_oe && !p_req_o) p_gap_seen = p_hi;
        p_hi = 0;
      end
    end
  end

  // double-driver monitor, both clock phases
  int overlap = 0;
  always @(clk) begin
    #1;
    if (rst_n) begin
      if (u_req_oe && p_req_oe)   overlap++;
      if (u_ack_oe && p_ack_oe)   overlap++;
      if (u_strb_oe && p_strb_oe) overlap++;
      if (u_rdy_oe && p_rdy_oe)   overlap++;
      if (u_dat_oe && p_dat_oe)   overlap++;
    end
  end

  initial begin
    #(4 * 20000);
    chk(1'b0, "R9", "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    int n;
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    mon_on = 1'b1;

    // R1 reset roles
    chk(u_dat_oe && u_strb_oe && u_ack_oe && u_ack_o, "R1", "holder drives data/strobe/ack high",
        {u_dat_oe, u_strb_oe, u_ack_oe, u_ack_o}, 15);
    chk(!u_req_oe && !u_rdy_oe && u_hold, "R1", "holder req/rdy undriven", {u_req_oe, u_rdy_oe, u_hold}, 1);
    chk(p_req_oe && p_req_o && p_rdy_oe, "R1", "non-holder drives req high and rdy",
        {p_req_oe, p_req_o, p_rdy_oe}, 7);
    chk(!p_dat_oe && !p_ack_oe && !p_strb_oe && !p_hold, "R1", "non-holder data/ack/strobe undriven",
        {p_dat_oe, p_ack_oe, p_strb_oe, p_hold}, 0);

    // R11 and R10 data path and synchronized control
    u_tx = 8'hA5;
    u_strbv = 1'b0;
    p_rdyv = 1'b0;
    tick();
    chk(dat_w == 8'hA5, "R11", "holder drives tx_data", dat_w, 8'hA5);
    chk(strb_w == 1'b0, "R11", "holder drives strobe value", strb_w, 0);
    chk(rdy_w == 1'b0, "R8", "non-holder drives word_rdy_n", rdy_w, 0);
    chk(p_dat_s == 8'hA5, "R10", "dat_s one cycle late", p_dat_s, 8'hA5);
    repeat (2) tick();
    chk(p_strb_s == 1'b0, "R10", "strb_s after synchronizer", p_strb_s, 0);
    chk(u_rdy_s == 1'b0, "R10", "rdy_s after synchronizer", u_rdy_s, 0);
    u_strbv = 1'b1;
    p_rdyv = 1'b1;
    repeat (3) tick();

    // handoff 1: uut -> peer
    expect_ev(1'b0, 1'b0);
    expect_ev(1'b1, 1'b1);
    p_want = 1'b1;
    n = 0;
    while (req_w && n < 20) begin tick(); n++; end
    chk(!req_w, "R2", "peer drives request low", req_w, 0);
    n = 0;
    while (ack_w && n < 10) begin tick(); n++; end
    chk(n >= 1 && n <= SYNC_STAGES + 1, "R3", "ack latency after request", n, SYNC_STAGES);
    chk(u_dat_oe == 1'b1, "R5", "data still driven at ack edge", u_dat_oe, 1);
    chk(p_rdy_oe == 1'b0, "R8", "requester rdy released on ack low", p_rdy_oe, 0);
    @(negedge clk);
    #1;
    chk(!u_dat_oe && u_rdy_oe && u_rdy_o, "R5", "half-period turnaround", {u_dat_oe, u_rdy_oe, u_rdy_o}, 3);
    n = 0;
    while (p_req_oe && n < 8) begin tick(); n++; end
    chk(!p_req_oe && req_w, "R6", "requester releases request", {p_req_oe, req_w}, 1);
    n = 0;
    while (!u_req_oe && n < 8) begin tick(); n++; end
    chk(u_req_oe && u_req_o && !u_ack_oe && !u_strb_oe, "R6", "old holder swaps req/ack/strobe",
        {u_req_oe, u_req_o, u_ack_oe, u_strb_oe}, 12);
    n = 0;
    while (!p_dat_oe && n < 3 * TAKE_GAP) begin tick(); n++; end
    chk(p_dat_oe && p_ack_oe && p_ack_o && p_strb_oe, "R7", "new holder takes data/ack high/strobe",
        {p_dat_oe, p_ack_oe, p_ack_o, p_strb_oe}, 15);
    p_want = 1'b0;
    p_tx = 8'h3C;
    tick();
    chk(u_dat_s == 8'h3C, "R11", "new holder data reaches old holder", u_dat_s, 8'h3C);
    repeat (3) tick();

    // handoff 2 (peer -> uut), then handoff 3 started by a waiting request (R2)
    expect_ev(1'b1, 1'b0);
    expect_ev(1'b0, 1'b1);
    expect_ev(1'b0, 1'b0);
    expect_ev(1'b1, 1'b1);
    p_want = 1'b1;
    u_want = 1'b1;
    n = 0;
    while (!u_hold && n < 60) begin tick(); n++; end
    chk(u_hold, "R7", "uut regains token", u_hold, 1);
    u_want = 1'b0;
    n = 0;
    while (!p_hold && n < 60) begin tick(); n++; end
    chk(p_hold, "R7", "peer regains token", p_hold, 1);
    p_want = 1'b0;
    chk(p_gap_seen == exp_gap(REQ_GAP), "R2", "request gap cycles", p_gap_seen, exp_gap(REQ_GAP));
    repeat (3) tick();

    // handoff 4: holder busy defers grant until ready low (R4)
    expect_ev(1'b1, 1'b0);
    expect_ev(1'b0, 1'b1);
    p_busy = 1'b1;
    u_rdyv = 1'b1;
    repeat (3) tick();
    u_want = 1'b1;
    repeat (12) tick();
    chk(ack_w && p_hold && !req_w, "R4", "grant held while ready high", {ack_w, p_hold, req_w}, 6);
    u_rdyv = 1'b0;
    n = 0;
    while (ack_w && n < 8) begin tick(); n++; end
    chk(!ack_w && n <= SYNC_STAGES + 2, "R4", "grant after ready low", n, SYNC_STAGES);
    n = 0;
    while (!u_hold && n < 40) begin tick(); n++; end
    u_want = 1'b0;
    p_busy = 1'b0;
    u_rdyv = 1'b1;
    repeat (4) tick();

    chk(exp_q.size() == 0, "R7", "all expected handoffs seen", exp_q.size(), 0);
    chk(overlap == 0, "R9", "double-driven pin samples", overlap, 0);
    finish_run();
  end

endmodule